// File: doc/BRIEF.md
# Smart Card Character Wait Time Monitor

This block watches the start-of-character strobes of a smart-card serial link and raises a sticky error when the time since the last relevant character start grows past a programmed limit. Time is measured in elementary time units (etu). A prescaler divides the serial clock into etu ticks, and an etu counter counts those ticks from the most recent qualifying character start.

Two protocol modes are supported. In the byte-oriented mode, a start in either direction restarts the measurement, and the limit is sixty times the wait setting. In the block-oriented mode, only received characters restart it, and the limit is the wait setting itself. Each mode replaces a zero wait setting with its own minimum. Two configuration registers hold the wait setting and the cycles-per-etu setting. Both are written through a simple strobe port and can be read back.

Top module: `wait_time_monitor`

## Requirements
- R1: After reset the wait register reads 0xFFFF, the etu register reads 0x0173 (371) and the error output is 0.
- R2: The etu register stores only its low 11 bits. Bits 15 to 11 always read as zero (writing 0xFFFF reads back 0x07FF). `cfg_sel_i`=0 selects the wait register and `cfg_sel_i`=1 selects the etu register.
- R3: One etu lasts (etu setting + 1) serial clock cycles, counted from the cycle in which a qualifying start is sampled.
- R4: In byte mode (`mode_i`=0) with a wait setting W>0, the error output rises exactly (60·W+1)·(etu+1) cycles after the clock edge that samples the last qualifying start, and not one cycle earlier.
- R5: In byte mode a wait setting of 0 acts as a limit of 60 etu.
- R6: In block mode (`mode_i`=1) with W>0, the error output rises exactly (W+1)·(etu+1) cycles after the last received-character start.
- R7: In block mode a wait setting of 0 acts as a limit of 1 etu.
- R8: In byte mode a transmit start restarts the measurement just as a receive start does.
- R9: In block mode a transmit start has no effect on the measurement.
- R10: No error is raised until the first qualifying start after reset or after enable rises. In block mode a transmit start does not arm the monitor.
- R11: The error output stays high until `err_clr_i` is pulsed. After a clear it does not rise again without a fresh limit crossing. The etu count saturates instead of wrapping.
- R12: A qualifying start that arrives before the limit is crossed restarts the count and prevents the error.
- R13: While `enable_i` is low no error is raised and the monitor disarms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Monitoring enable |
| mode_i | input | 1 | 0 = byte protocol, 1 = block protocol |
| tx_start_i | input | 1 | One-cycle strobe at a transmitted character start |
| rx_start_i | input | 1 | One-cycle strobe at a received character start |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = wait register, 1 = etu register |
| cfg_wdata_i | input | 16 | Configuration write data |
| err_clr_i | input | 1 | Clears the error flag |
| wait_q_o | output | 16 | Wait register contents |
| etu_q_o | output | 16 | Etu register contents (upper 5 bits zero) |
| wait_err_o | output | 1 | Sticky wait-time error |

## Verification
The bench builds the block with its default parameters: 16-bit wait setting, 11-bit etu setting and a scale of 60, which gives a 22-bit etu counter. It keeps the programmed etu setting between 0 and 3 and the wait setting small, so every limit crossing in both modes, including both zero substitutes, occurs within a few hundred cycles. The error edge can then be checked on its exact cycle. Saturation of the counter near 2^22 etu is out of reach in that time and is guarded by an assertion instead.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  typedef enum logic {
    PROTO_BYTE  = 1'b0,
    PROTO_BLOCK = 1'b1
  } proto_e;
endpackage

// File: rtl/wtm_cfg_regs.sv
module wtm_cfg_regs #(
  parameter int REG_W    = 16,
  parameter int WAIT_W   = 16,
  parameter int ETU_W    = 11,
  parameter logic [WAIT_W-1:0] WAIT_RST = '1,
  parameter logic [ETU_W-1:0]  ETU_RST  = ETU_W'(371)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [WAIT_W-1:0] wait_o,
  output logic [ETU_W-1:0]  etu_o
);
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [ETU_W-1:0]  etu_q, etu_d;
  logic              wait_en, etu_en;

  always_comb begin
    wait_en = we_i && !sel_i;
    etu_en  = we_i && sel_i;
    wait_d  = wdata_i[WAIT_W-1:0];
    etu_d   = wdata_i[ETU_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= WAIT_RST;
      etu_q  <= ETU_RST;
    end else begin
      if (wait_en) wait_q <= wait_d;
      if (etu_en)  etu_q  <= etu_d;
    end
  end

  assign wait_o = wait_q;
  assign etu_o  = etu_q;

  p_hold_regs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(wait_q) && $stable(etu_q));
endmodule

// File: rtl/wtm_prescaler.sv
module wtm_prescaler #(
  parameter int ETU_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [ETU_W-1:0] cfg_i,
  output logic             tick_o
);
  logic [ETU_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  always_comb begin
    at_end = (cnt_q == cfg_i);
    tick_o = run_i && !restart_i && at_end;
    if (!run_i || restart_i || at_end) cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && cfg_i != '0 |=> !tick_o || cfg_i == '0);
  p_restart_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/wtm_etu_counter.sv
module wtm_etu_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;

  always_comb begin
    full    = &cnt_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (!enable_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (start_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (tick_i && armed_q && !full) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed_o = armed_q;
  assign cnt_o   = cnt_q;

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == '0);
  p_no_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q) && enable_i && !start_i |=> &cnt_q);
  p_idle_unarmed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> cnt_q == '0);
  p_disable_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !armed_q);
endmodule

// File: rtl/wtm_limit.sv
module wtm_limit
  import wtm_pkg::*;
#(
  parameter int WAIT_W   = 16,
  parameter int CNT_W    = 22,
  parameter int T0_SCALE = 60
) (
  input  proto_e            mode_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic [CNT_W-1:0]  limit_o
);
  logic [CNT_W-1:0] w_ext, scaled;
  logic             w_zero;

  always_comb begin
    w_ext  = CNT_W'(wait_i);
    w_zero = (wait_i == '0);
    scaled = w_ext * CNT_W'(T0_SCALE);
    if (mode_i == PROTO_BYTE) limit_o = w_zero ? CNT_W'(T0_SCALE) : scaled;
    else                      limit_o = w_zero ? CNT_W'(1)        : w_ext;
  end

  always_comb begin
    assert (limit_o != '0);
  end
endmodule

// File: rtl/wait_time_monitor.sv
module wait_time_monitor
  import wtm_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int WAIT_W   = 16,
  parameter int ETU_W    = 11,
  parameter int T0_SCALE = 60,
  parameter logic [WAIT_W-1:0] WAIT_RST = '1,
  parameter logic [ETU_W-1:0]  ETU_RST  = ETU_W'(371)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             mode_i,
  input  logic             tx_start_i,
  input  logic             rx_start_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             err_clr_i,
  output logic [REG_W-1:0] wait_q_o,
  output logic [REG_W-1:0] etu_q_o,
  output logic             wait_err_o
);
  localparam int CNT_W = WAIT_W + $clog2(T0_SCALE);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  proto_e            mode;
  logic              qual_start;
  logic              etu_tick;
  logic              armed;
  logic [CNT_W-1:0]  etu_cnt;
  logic [CNT_W-1:0]  limit;
  logic [WAIT_W-1:0] wait_val;
  logic [ETU_W-1:0]  etu_val;
  logic              err_q, err_d, err_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    mode       = proto_e'(mode_i);
    qual_start = enable_i && (rx_start_i || (mode == PROTO_BYTE && tx_start_i));
  end

  wtm_cfg_regs #(
    .REG_W(REG_W), .WAIT_W(WAIT_W), .ETU_W(ETU_W),
    .WAIT_RST(WAIT_RST), .ETU_RST(ETU_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .wait_o(wait_val), .etu_o(etu_val)
  );

  wtm_prescaler #(.ETU_W(ETU_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(enable_i), .restart_i(qual_start),
    .cfg_i(etu_val), .tick_o(etu_tick)
  );

  wtm_etu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .enable_i(enable_i), .start_i(qual_start),
    .tick_i(etu_tick), .armed_o(armed), .cnt_o(etu_cnt)
  );

  wtm_limit #(.WAIT_W(WAIT_W), .CNT_W(CNT_W), .T0_SCALE(T0_SCALE)) u_lim (
    .mode_i(mode), .wait_i(wait_val), .limit_o(limit)
  );

  always_comb begin
    err_set = etu_tick && armed && !qual_start && (etu_cnt == limit);
    if (err_set)        err_d = 1'b1;
    else if (err_clr_i) err_d = 1'b0;
    else                err_d = err_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign wait_q_o   = REG_W'(wait_val);
  assign etu_q_o    = REG_W'(etu_val);
  assign wait_err_o = err_q;

  p_err_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(err_q) |-> $past(etu_tick));
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_q && !err_clr_i |=> err_q);
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_clr_i && !etu_tick |=> !err_q);
  p_off_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_n)
    !enable_i && !err_q |=> !err_q);
endmodule

// File: tb/test_wait_time_monitor.sv
module test_wait_time_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        mode = 1'b0;
  logic        tx_start = 1'b0;
  logic        rx_start = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        err_clr = 1'b0;
  logic [15:0] wait_q, etu_q;
  logic        wait_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wait_time_monitor i_wait_time_monitor (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .mode_i(mode),
    .tx_start_i(tx_start), .rx_start_i(rx_start), .cfg_we_i(cfg_we),
    .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .err_clr_i(err_clr),
    .wait_q_o(wait_q), .etu_q_o(etu_q), .wait_err_o(wait_err)
  );

  function automatic int exp_limit(input bit blk, input int w);
    if (blk) return (w == 0) ? 1 : w;
    return (w == 0) ? 60 : 60 * w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input bit rx, input bit tx, input bit clr);
    rx_start = rx; tx_start = tx; err_clr = clr;
    @(posedge clk); #2;
    rx_start = 1'b0; tx_start = 1'b0; err_clr = 1'b0;
  endtask

  // Called just after edge E; error must rise exactly at edge E+n.
  task automatic boundary(input string req, input int n);
    repeat (n - 1) @(posedge clk);
    #2; check(req, wait_err, 0);
    @(posedge clk); #2; check(req, wait_err, 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    #23 rst_n = 1'b1;
    idle(3);
    check("R1 wait reset", wait_q, 16'hFFFF);
    check("R1 etu reset", etu_q, 16'h0173);
    check("R1 err reset", wait_err, 0);

    wr(1'b1, 16'hFFFF);
    check("R2 etu upper zero", etu_q, 16'h07FF);
    wr(1'b0, 16'h0000);
    check("R2 wait write", wait_q, 16'h0000);

    // R10: nothing armed yet
    wr(1'b1, 16'd1);
    idle(200);
    check("R10 unarmed byte", wait_err, 0);
    mode = 1'b1;
    pulse(1'b0, 1'b1, 1'b0);
    idle(20);
    check("R10 tx does not arm block", wait_err, 0);

    // R5: byte mode, zero wait -> 60 etu, etu = 2 cycles
    mode = 1'b0;
    pulse(1'b1, 1'b0, 1'b1);
    boundary("R5 byte zero wait", 61 * 2);

    // R7: block mode, zero wait -> 1 etu
    mode = 1'b1;
    pulse(1'b1, 1'b0, 1'b1);
    boundary("R7 block zero wait", 2 * 2);

    // R4 / R3: byte mode W=2, etu setting 3
    mode = 1'b0;
    wr(1'b0, 16'd2);
    wr(1'b1, 16'd3);
    pulse(1'b1, 1'b0, 1'b1);
    boundary("R4 R3 byte W=2", 121 * 4);

    // R8: tx restarts in byte mode (W=1, etu 2 cycles)
    wr(1'b0, 16'd1);
    wr(1'b1, 16'd1);
    pulse(1'b1, 1'b0, 1'b1);
    idle(100);
    pulse(1'b0, 1'b1, 1'b0);
    boundary("R8 tx restart byte", 61 * 2);

    // R9: tx ignored in block mode (W=5)
    mode = 1'b1;
    wr(1'b0, 16'd5);
    pulse(1'b1, 1'b0, 1'b1);
    idle(5);
    pulse(1'b0, 1'b1, 1'b0);
    boundary("R9 tx ignored block", 12 - 6);

    // R12 / R6: rx before limit restarts (W=4)
    wr(1'b0, 16'd4);
    pulse(1'b1, 1'b0, 1'b1);
    idle(8);
    pulse(1'b1, 1'b0, 1'b0);
    boundary("R12 R6 restart block", 5 * 2);

    // R13: disable during count
    mode = 1'b0;
    wr(1'b0, 16'd0);
    pulse(1'b1, 1'b0, 1'b1);
    idle(60);
    enable = 1'b0;
    idle(200);
    check("R13 disabled quiet", wait_err, 0);
    enable = 1'b1;
    idle(200);
    check("R13 R10 re-enable unarmed", wait_err, 0);
    pulse(1'b1, 1'b0, 1'b0);
    boundary("R13 re-armed", 61 * 2);

    // R11: sticky, then clear
    idle(10);
    check("R11 sticky", wait_err, 1);
    pulse(1'b0, 1'b0, 1'b1);
    check("R11 cleared", wait_err, 0);
    idle(50);
    check("R11 no re-set", wait_err, 0);

    // Random trials
    for (int i = 0; i < 10; i++) begin
      bit blk;
      int w, e;
      string tag;
      blk = 1'($urandom % 2);
      w   = blk ? int'($urandom % 12) : int'($urandom % 3);
      e   = int'($urandom % 4);
      mode = blk;
      wr(1'b0, 16'(w));
      wr(1'b1, 16'(e));
      pulse(1'b1, 1'b0, 1'b1);
      tag = blk ? ((w == 0) ? "R7 random" : "R6 random")
                : ((w == 0) ? "R5 random" : "R4 random");
      boundary(tag, (exp_limit(blk, w) + 1) * (e + 1));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule